// File: doc/BRIEF.md
# Late-Write Burst SRAM Core

A synchronous single-port static memory with a command interface that never needs an idle cycle when the bus turns between reading and writing. An operation is loaded on a clock edge when the load strobe is low and all three chip selects are in their active state. The address and the read/write type are registered on that edge. A read drives data combinationally from the array during the cycle that follows the loading edge. A write takes its data and byte enables one enabled edge later. A write can therefore be followed at once by a read, or a read by a write, and every cycle carries data.

With the load strobe high, the core continues the current operation as a four-beat wrapping burst. The two low address bits seed a 2-bit beat counter, and the burst order (linear or interleaved) is chosen when the burst is loaded. Write data that has been sampled but not yet committed sits in a late-write holding register. A read of that address is served from the register, merged per byte with the array word. A high clock enable freezes the whole core. The output enable is asynchronous and only gates the per-byte drive strobes.

Top module: `lw_burst_sram`

## Requirements
- R1: A synchronous active-high reset leaves the core idle with no pending write, so every bit of `rdata_oe` is 0 in the cycle after reset.
- R2: An operation loads on an edge where `clk_en_n`=0, `ld_n`=0, `sel1_n`=0, `sel2`=1 and `sel3_n`=0. `wr_n`=1 loads a read and `wr_n`=0 loads a write.
- R3: On an enabled edge with `ld_n`=0 and any chip select inactive, the core becomes idle. On an enabled edge with `ld_n`=1 while idle, it stays idle. An idle core drives no strobes and writes nothing.
- R4: A read is flow-through. During the cycle after the edge that loads or advances it, `rdata` holds the word at the current beat address and `rdata_oe` is all ones.
- R5: For a write beat, `wdata` and `byte_wr_n` are sampled at the next enabled edge after the one that registered the beat's address, whatever that edge also loads.
- R6: Byte lane b (bits b*BW to b*BW+BW-1) is written only when `byte_wr_n[b]`=0. All ones aborts the write and leaves memory unchanged, but the burst still advances.
- R7: With `burst_ilv`=0 at load, beat n of a burst uses low address bits (start+n) mod 4. After four beats the sequence wraps to the start.
- R8: With `burst_ilv`=1 at load, beat n uses low address bits start XOR n.
- R9: An enabled edge with `ld_n`=1 during a read or write continues the burst with the type latched at load. The upper address bits stay unchanged.
- R10: While `clk_en_n`=1, every synchronous input is ignored. The beat counter, the operation state and the pending write all hold.
- R11: With `out_en_n`=1, `rdata_oe` is all zeros whatever the cycle type. A read made this way is a dummy read with no effect on memory.
- R12: A read of an address whose write data is still pending returns the pending bytes for enabled lanes and the array bytes for the others.
- R13: Reads and writes can alternate on consecutive edges with no idle cycle, and every read returns the most recently written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock enable, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low: load a new command; high: advance burst |
| wr_n | input | 1 | Low: write; high: read (sampled at load) |
| byte_wr_n | input | NB | Per-byte write enables, active low, sampled one cycle late |
| addr | input | AW | Word address |
| wdata | input | NB*BW | Write data, sampled one cycle late |
| burst_ilv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | NB*BW | Read data |
| rdata_oe | output | NB | Per-byte output drive strobes |

## Verification
The memory is first filled with back-to-back writes, so every write sits in the holding register when the next command loads. The bench then reads each address back as single-beat reads. Immediate write-then-read pairs to the same address with partial byte masks separate a correct bypass merge from one that returns stale array data or a whole-word value. Four-beat bursts from every start offset in both orders, including aborted write bursts, show whether the counter wraps and whether the type stays latched. Held clock enables inside bursts, deselects through each select, and dummy reads show that frozen or ignored cycles change nothing. A long random mix of all of these, aimed at a few hot addresses, exposes turnaround hazards.

// File: rtl/lw_burst_sram.sv
module lw_burst_sram #(
  parameter int AW = 6,
  parameter int NB = 4,
  parameter int BW = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clk_en_n,
  input  logic               sel1_n,
  input  logic               sel2,
  input  logic               sel3_n,
  input  logic               ld_n,
  input  logic               wr_n,
  input  logic [NB-1:0]      byte_wr_n,
  input  logic [AW-1:0]      addr,
  input  logic [NB*BW-1:0]   wdata,
  input  logic               burst_ilv,
  input  logic               out_en_n,
  output logic [NB*BW-1:0]   rdata,
  output logic [NB-1:0]      rdata_oe
);
  localparam int DW    = NB * BW;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} op_t;

  op_t              op_q;
  logic [AW-3:0]    hi_q;
  logic [1:0]       start_q, cnt_q;
  logic             ilv_q;
  logic             pend_vld;
  logic [AW-1:0]    pend_addr;
  logic [DW-1:0]    pend_data;
  logic [NB-1:0]    pend_be_n;
  logic [DW-1:0]    mem [DEPTH];

  wire          sel_ok   = !sel1_n && sel2 && !sel3_n;
  wire          step_en  = !clk_en_n;
  wire [1:0]    cur_lsb  = ilv_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
  wire [AW-1:0] cur_addr = {hi_q, cur_lsb};
  wire [DW-1:0] arr_word = mem[cur_addr];
  wire          pend_hit = pend_vld && (pend_addr == cur_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= OP_IDLE;
      pend_vld <= 1'b0;
      cnt_q    <= 2'd0;
      start_q  <= 2'd0;
      hi_q     <= '0;
      ilv_q    <= 1'b0;
    end else if (step_en) begin
      pend_vld  <= (op_q == OP_WRITE);
      pend_addr <= cur_addr;
      pend_data <= wdata;
      pend_be_n <= byte_wr_n;
      if (!ld_n) begin
        if (sel_ok) begin
          op_q    <= wr_n ? OP_READ : OP_WRITE;
          hi_q    <= addr[AW-1:2];
          start_q <= addr[1:0];
          cnt_q   <= 2'd0;
          ilv_q   <= burst_ilv;
        end else begin
          op_q <= OP_IDLE;
        end
      end else if (op_q != OP_IDLE) begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if ((rst || step_en) && pend_vld) begin
      for (int b = 0; b < NB; b++) begin
        if (!pend_be_n[b]) mem[pend_addr][b*BW +: BW] <= pend_data[b*BW +: BW];
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign rdata[g*BW +: BW] = (pend_hit && !pend_be_n[g]) ? pend_data[g*BW +: BW]
                                                           : arr_word[g*BW +: BW];
  end

  assign rdata_oe = {NB{(op_q == OP_READ) && !out_en_n}};
endmodule

// File: rtl/lw_burst_sram_chk.sv
module lw_burst_sram_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_en_n,
  input logic          ld_n,
  input logic          sel1_n,
  input logic          sel2,
  input logic          sel3_n,
  input logic          out_en_n,
  input logic [NB-1:0] rdata_oe,
  input logic [1:0]    op,
  input logic [1:0]    cnt,
  input logic [1:0]    lsb,
  input logic          ilv,
  input logic          pend_vld
);
  wire sel_bad = sel1_n || !sel2 || sel3_n;

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (op == 2'd0) && !pend_vld);

  p_desel_r3: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !ld_n && sel_bad) |=> (op == 2'd0));

  p_idle_stays_r3: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && ld_n && op == 2'd0) |=> (op == 2'd0));

  p_late_data_r5: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && op == 2'd2) |=> pend_vld);

  p_lin_step_r7: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && ld_n && op != 2'd0 && !ilv) |=> (lsb == $past(lsb) + 2'd1));

  p_keep_type_r9: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && ld_n && op != 2'd0) |=> (op == $past(op)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(op) && $stable(cnt) && $stable(pend_vld)));

  p_oe_off_r11: assert property (@(posedge clk) disable iff (rst)
    out_en_n |-> (rdata_oe == '0));
endmodule

bind lw_burst_sram lw_burst_sram_chk #(.NB(NB)) chk_i (
  .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .ld_n(ld_n),
  .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .out_en_n(out_en_n),
  .rdata_oe(rdata_oe), .op(op_q), .cnt(cnt_q), .lsb(cur_lsb),
  .ilv(ilv_q), .pend_vld(pend_vld)
);

// File: tb/lw_burst_sram_tb_top.sv
module lw_burst_sram_tb_top;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1;
  logic clk_en_n = 0, sel1_n = 1, sel2 = 0, sel3_n = 1, ld_n = 1, wr_n = 1;
  logic [NB-1:0] byte_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic burst_ilv = 0, out_en_n = 0;
  logic [DW-1:0] rdata;
  logic [NB-1:0] rdata_oe;

  always #5 clk = ~clk;

  lw_burst_sram #(.AW(AW), .NB(NB), .BW(BW)) dut_i (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .sel1_n(sel1_n), .sel2(sel2),
    .sel3_n(sel3_n), .ld_n(ld_n), .wr_n(wr_n), .byte_wr_n(byte_wr_n), .addr(addr),
    .wdata(wdata), .burst_ilv(burst_ilv), .out_en_n(out_en_n),
    .rdata(rdata), .rdata_oe(rdata_oe));

  int n_tests = 0, n_fail = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [1:0] m_op = 2'd0;
  logic [AW-3:0] m_hi = '0;
  logic [1:0] m_start = 2'd0, m_cnt = 2'd0;
  logic m_ilv = 1'b0;

  logic [DW-1:0] wd_q [$];
  logic [NB-1:0] wbe_q [$];
  logic          exp_oe_q [$];
  logic [DW-1:0] exp_d_q [$];
  string         tag_q [$];

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] l;
    l = m_ilv ? (m_start ^ m_cnt) : (m_start + m_cnt);
    return {m_hi, l};
  endfunction

  function automatic logic [DW-1:0] rnd();
    return DW'({$urandom(), $urandom()});
  endfunction

  task automatic step(input logic cke_n, input logic ld, input int selc, input logic wr,
                      input logic [AW-1:0] a, input logic ilv, input logic oen, input string tag);
    @(negedge clk);
    clk_en_n = cke_n; ld_n = ld; wr_n = wr; addr = a; burst_ilv = ilv; out_en_n = oen;
    sel1_n = (selc == 1); sel2 = (selc != 2); sel3_n = (selc == 3);
    if (!cke_n && !rst && m_op == 2'd2 && wd_q.size() > 0) begin
      wdata = wd_q.pop_front(); byte_wr_n = wbe_q.pop_front();
    end else begin
      wdata = rnd(); byte_wr_n = NB'($urandom());
    end
    @(posedge clk); #1;
    if (rst) m_op = 2'd0;
    else if (!cke_n) begin
      if (m_op == 2'd2)
        for (int b = 0; b < NB; b++)
          if (!byte_wr_n[b]) ref_mem[m_addr()][b*BW +: BW] = wdata[b*BW +: BW];
      if (!ld) begin
        if (selc == 0) begin
          m_op = wr ? 2'd1 : 2'd2; m_hi = a[AW-1:2]; m_start = a[1:0];
          m_cnt = 2'd0; m_ilv = ilv;
        end else m_op = 2'd0;
      end else if (m_op != 2'd0) m_cnt = m_cnt + 2'd1;
    end
    exp_oe_q.push_back(m_op == 2'd1 && !oen);
    exp_d_q.push_back(ref_mem[m_addr()]);
    tag_q.push_back(tag);
  endtask

  task automatic ld_rd(input logic [AW-1:0] a, input logic ilv, input logic oen, input string tag);
    step(0, 0, 0, 1, a, ilv, oen, tag);
  endtask
  task automatic ld_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NB-1:0] be,
                       input logic ilv, input string tag);
    wd_q.push_back(d); wbe_q.push_back(be);
    step(0, 0, 0, 0, a, ilv, 0, tag);
  endtask
  task automatic cont(input logic [DW-1:0] d, input logic [NB-1:0] be, input logic oen, input string tag);
    if (m_op == 2'd2) begin wd_q.push_back(d); wbe_q.push_back(be); end
    step(0, 1, 0, 1, AW'($urandom()), 1'($urandom()), oen, tag);
  endtask
  task automatic hold(input string tag);
    step(1, 1'($urandom()), 0, 1'($urandom()), AW'($urandom()), 1'($urandom()), 0, tag);
  endtask
  task automatic desel(input int selc, input logic ld, input string tag);
    step(0, ld, selc, 1'($urandom()), AW'($urandom()), 0, 0, tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk); #3;
      if (exp_oe_q.size() > 0) begin
        logic eo; logic [DW-1:0] ed; string t;
        eo = exp_oe_q.pop_front(); ed = exp_d_q.pop_front(); t = tag_q.pop_front();
        n_tests++;
        if (rdata_oe !== {NB{eo}}) begin
          n_fail++;
          $display("FAIL %s: rdata_oe actual %b expected %b", t, rdata_oe, {NB{eo}});
        end else if (eo && rdata !== ed) begin
          n_fail++;
          $display("FAIL %s: rdata actual %h expected %h", t, rdata, ed);
        end
      end
    end
  end

  initial begin : watchdog
    #2000000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : driver
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    rst = 1;
    repeat (3) step(0, 0, 0, 1, 0, 0, 0, "R1 reset");
    rst = 0;
    step(0, 1, 0, 1, 0, 0, 0, "R1 idle after reset");

    for (int i = 0; i < DEPTH; i++) ld_wr(AW'(i), rnd(), '0, 0, "R2 R13 fill");
    desel(1, 0, "R3 desel sel1");
    for (int i = 0; i < DEPTH; i++) ld_rd(AW'(i), 0, 0, "R4 single read");

    // R12 bypass with partial masks, back-to-back turnarounds
    for (int i = 0; i < 16; i++) begin
      a = AW'($urandom()); d = rnd();
      ld_wr(a, d, NB'($urandom()), 0, "R5 R6 partial write");
      ld_rd(a, 0, 0, "R12 bypass read");
      ld_wr(AW'(a + 1), rnd(), '0, 0, "R13 turnaround write");
      ld_rd(AW'(a + 1), 0, 0, "R13 turnaround read");
    end
    ld_wr(5, rnd(), 4'b0101, 0, "R5 late write");
    ld_rd(9, 0, 0, "R5 other read while pending");
    ld_rd(5, 0, 0, "R6 lanes after commit");

    // bursts, every start, both orders
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 2; o++) begin
        ld_wr(AW'(16 + s), rnd(), '0, 1'(o), o ? "R8 ilv write burst" : "R7 lin write burst");
        for (int k = 0; k < 4; k++) cont(rnd(), NB'($urandom()), 0, "R9 write beat");
        ld_rd(AW'(16 + ((s + 1) % 4)), 1'(o), 0, o ? "R8 ilv read" : "R7 lin read");
        for (int k = 0; k < 5; k++) cont('0, '0, 0, o ? "R8 ilv wrap" : "R7 lin wrap");
      end
    end
    ld_wr(32, rnd(), '1, 0, "R6 abort burst");
    for (int k = 0; k < 3; k++) cont(rnd(), '1, 0, "R6 abort beat");
    ld_rd(32, 0, 0, "R6 after abort");
    for (int k = 0; k < 3; k++) cont('0, '0, 0, "R6 after abort");

    // clock enable hold
    ld_rd(40, 1, 0, "R10 read before hold");
    hold("R10 hold in read"); hold("R10 hold in read");
    cont('0, '0, 0, "R10 resume read");
    ld_wr(41, rnd(), '0, 0, "R10 write before hold");
    hold("R10 hold pending data"); hold("R10 hold pending data");
    ld_rd(41, 0, 0, "R10 data after hold");
    cont('0, '0, 0, "R10 resume");

    // output enable off
    ld_rd(3, 0, 1, "R11 dummy read");
    cont('0, '0, 1, "R11 dummy burst");
    cont('0, '0, 0, "R11 oe back on");

    // deselects
    ld_wr(50, rnd(), '0, 0, "R3 write then desel");
    desel(2, 0, "R3 desel sel2");
    desel(3, 0, "R3 desel sel3");
    desel(0, 1, "R3 continued desel");
    step(0, 0, 1, 0, 51, 0, 0, "R3 write with sel1 off");
    desel(0, 1, "R3 continued desel");
    ld_rd(51, 0, 0, "R3 unchanged");
    ld_rd(50, 0, 0, "R3 last write landed");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int c;
      c = $urandom_range(0, 9);
      a = ($urandom_range(0, 1) != 0) ? AW'($urandom_range(0, 7)) : AW'($urandom());
      case (c)
        0, 1, 2: ld_rd(a, 1'($urandom()), ($urandom_range(0, 7) == 0), "R13 random read");
        3, 4, 5: ld_wr(a, rnd(), NB'($urandom()), 1'($urandom()), "R13 random write");
        6, 7:    cont(rnd(), NB'($urandom()), 0, "R9 random continue");
        8:       hold("R10 random hold");
        default: desel($urandom_range(1, 3), 0, "R3 random desel");
      endcase
    end
    desel(1, 0, "R3 final");
    repeat (3) @(posedge clk);
    #5;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule